// File: doc/BRIEF.md
# Unaligned Word Load Merger

This block turns a 4-byte load at an arbitrary byte address into reads of a memory that only delivers naturally aligned 8-byte beats. When the word lies entirely inside one beat, a single read is issued. When it straddles an 8-byte boundary, two aligned reads go out on consecutive cycles, the lower beat first. The four wanted bytes are then cut out of the 8 or 16 bytes returned.

A byte-order input chosen per request decides how those bytes are packed into the 32-bit result. The input is captured when the request is taken, so software may change the order between any two loads. The memory side is a one-cycle read strobe with an address, answered a fixed number of cycles later by a data-valid strobe and the beat. The block handles one load at a time. It shows a busy flag while a load is in progress.

Top module: `unaligned_load_merger`

## Requirements
- R1: A request taken (req_valid high while busy is low) produces mem_rd high in the very next cycle, with mem_addr equal to req_addr with its three low bits forced to zero.
- R2: If req_addr[2:0] is 4 or less, exactly one read is issued. If it is 5, 6 or 7, a second read follows in the cycle right after the first, at the first address plus 8 (modulo the address width). No third read follows.
- R3: Byte lane k of mem_rdata (bits 8k+7 down to 8k) holds the byte stored at beat address + k. The result is made of the bytes at req_addr, req_addr+1, req_addr+2 and req_addr+3, with addresses wrapping at the top of the address space.
- R4: With req_big_end low at acceptance, the byte at req_addr lands in rsp_data[7:0], and the byte at req_addr+3 lands in rsp_data[31:24].
- R5: With req_big_end high at acceptance, the byte at req_addr lands in rsp_data[31:24], and the byte at req_addr+3 lands in rsp_data[7:0].
- R6: req_big_end is sampled only at acceptance. Changing it while busy has no effect on the load in progress. Consecutive loads may use different orders.
- R7: busy is high from the cycle after acceptance up to the cycle before rsp_valid, and low in the rsp_valid cycle. A request presented while busy is high causes no memory read and no result.
- R8: rsp_valid is high for exactly one cycle per accepted request. It comes two cycles after the cycle in which the last needed beat's mem_rvalid was high.
- R9: During and right after reset, busy, mem_rd and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | ADDR_W | Byte address of the word |
| req_big_end | input | 1 | 1 = big-endian packing, 0 = little-endian |
| busy | output | 1 | Load in progress; requests are ignored |
| mem_rd | output | 1 | Aligned beat read strobe |
| mem_addr | output | ADDR_W | Beat address (low three bits zero) |
| mem_rvalid | input | 1 | Beat data valid |
| mem_rdata | input | 8*BEAT_BYTES | Returned beat, lane k = address base+k |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8*WORD_BYTES | Assembled word |

## Verification
The assertions assume that the memory answers each read exactly once, in order, and never sooner than one cycle after the strobe. A beat therefore cannot arrive while the second read is being issued, and no data-valid arrives unrequested. The bench's memory model is a fixed three-stage delay line fed only by mem_rd, so it meets this. The bench also presents extra requests while busy, so that ignoring them is tested. It withdraws them before busy can fall, so that none of them is taken by accident.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD2  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } lm_state_t;
endpackage

// File: rtl/lm_addr_split.sv
`timescale 1ns/1ps
module lm_addr_split #(
  parameter int ADDR_W     = 16,
  parameter int BEAT_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(BEAT_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] next_base,
  output logic [OFF_W-1:0]  off,
  output logic              two_beats
);
  localparam int LAST_FIT = BEAT_BYTES - WORD_BYTES;

  always_comb begin
    off       = addr[OFF_W-1:0];
    base      = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    next_base = base + ADDR_W'(BEAT_BYTES);
    two_beats = (int'(off) > LAST_FIT);
  end
endmodule

// File: rtl/lm_req_ctrl.sv
`timescale 1ns/1ps
module lm_req_ctrl
  import lm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BEAT_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(BEAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_big_end,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [OFF_W-1:0]  off_q,
  output logic              be_q,
  output logic              buf_wr,
  output logic              buf_sel,
  output logic              fire
);
  lm_state_t        state;
  logic             two_q;
  logic             rcv_q;
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] sp_base, sp_next;
  logic [OFF_W-1:0]  sp_off;
  logic              sp_two;

  lm_addr_split #(
    .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_split (
    .addr(req_addr), .base(sp_base), .next_base(sp_next),
    .off(sp_off), .two_beats(sp_two)
  );

  always_comb begin
    buf_wr  = (state == S_WAIT) && mem_rvalid;
    buf_sel = rcv_q;
    fire    = (state == S_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      next_q   <= '0;
      off_q    <= '0;
      be_q     <= 1'b0;
      two_q    <= 1'b0;
      rcv_q    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            busy     <= 1'b1;
            mem_rd   <= 1'b1;
            mem_addr <= sp_base;
            next_q   <= sp_next;
            off_q    <= sp_off;
            be_q     <= req_big_end;
            two_q    <= sp_two;
            rcv_q    <= 1'b0;
            state    <= sp_two ? S_RD2 : S_WAIT;
          end
        end
        S_RD2: begin
          mem_rd   <= 1'b1;
          mem_addr <= next_q;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            rcv_q <= 1'b1;
            if (!two_q || rcv_q) state <= S_DONE;
          end
        end
        default: begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R1: every beat read is naturally aligned
  assert_aligned_read_R1: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[OFF_W-1:0] == '0));

  // R2: a back-to-back second read targets the following beat
  assert_second_beat_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));

  // R2: never three reads in a row
  assert_no_third_read_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  // R7: reads only go out while a load is in progress
  assert_read_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R6: captured byte order does not move during a load
  assert_order_held_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(be_q));
endmodule

// File: rtl/lm_beat_buf.sv
`timescale 1ns/1ps
module lm_beat_buf #(
  parameter int BEAT_BYTES = 8,
  parameter int SLOTS      = 2,
  localparam int BEAT_W    = 8 * BEAT_BYTES,
  localparam int SEL_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [BEAT_W-1:0]       wr_data,
  output logic [SLOTS*BEAT_W-1:0] rd_flat
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == SEL_W'(g))) slot_q <= wr_data;
    end
    assign rd_flat[g*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/lm_byte_pick.sv
`timescale 1ns/1ps
module lm_byte_pick #(
  parameter int BEAT_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(BEAT_BYTES),
  localparam int IDX_W     = OFF_W + 1,
  localparam int SPAN_W    = 16 * BEAT_BYTES,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [OFF_W-1:0]  off,
  input  logic              big_end,
  input  logic [SPAN_W-1:0] span,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic [WORD_W-1:0] le_word, be_word;

  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic [7:0]       lane;
    assign idx  = {1'b0, off} + IDX_W'(j);
    assign lane = span[idx*8 +: 8];
    assign le_word[j*8 +: 8]                  = lane;
    assign be_word[(WORD_BYTES-1-j)*8 +: 8]   = lane;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_data <= big_end ? be_word : le_word;
    end
  end

  // R8: result strobe is a single-cycle pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/unaligned_load_merger.sv
`timescale 1ns/1ps
module unaligned_load_merger #(
  parameter int ADDR_W     = 16,
  parameter int BEAT_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(BEAT_BYTES),
  localparam int BEAT_W    = 8 * BEAT_BYTES,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_big_end,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [BEAT_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic [OFF_W-1:0]    off_q;
  logic                be_q;
  logic                buf_wr, buf_sel, fire;
  logic [2*BEAT_W-1:0] span;

  lm_req_ctrl #(
    .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid && !busy), .req_addr(req_addr), .req_big_end(req_big_end),
    .mem_rvalid(mem_rvalid),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .off_q(off_q), .be_q(be_q),
    .buf_wr(buf_wr), .buf_sel(buf_sel), .fire(fire)
  );

  lm_beat_buf #(.BEAT_BYTES(BEAT_BYTES), .SLOTS(2)) u_buf (
    .clk(clk), .wr_en(buf_wr), .wr_sel(buf_sel),
    .wr_data(mem_rdata), .rd_flat(span)
  );

  lm_byte_pick #(.BEAT_BYTES(BEAT_BYTES), .WORD_BYTES(WORD_BYTES)) u_pick (
    .clk(clk), .rst(rst), .fire(fire), .off(off_q), .big_end(be_q),
    .span(span), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R7: busy only drops in the cycle the result is presented
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid);

  // R7: no result appears without a load having been in progress
  assert_result_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(busy));
endmodule

// File: tb/unaligned_load_merger_bench.sv
`timescale 1ns/1ps
module unaligned_load_merger_bench;
  localparam int AW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic          req_big_end = 1'b0;
  logic          busy, mem_rd, mem_rvalid, rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_rdata;
  logic [31:0]   rsp_data;

  int total = 0, bad = 0, cyc = 0, last_rv = 0, rd_count = 0, rd_expect = 0;
  bit prev_rsp = 1'b0;
  logic [31:0] exp_q[$];
  string       msg_q[$];

  unaligned_load_merger u_unaligned_load_merger (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_big_end(req_big_end), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h11;
  endfunction

  function automatic logic [31:0] expw(input logic [AW-1:0] a, input bit be);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) begin
      if (be) w[(3-j)*8 +: 8] = mb(a + AW'(j));
      else    w[j*8 +: 8]     = mb(a + AW'(j));
    end
    return w;
  endfunction

  // memory model: fixed latency delay line, lane k = base + k (R3)
  logic          pv [LAT];
  logic [AW-1:0] pa [LAT];
  always @(posedge clk) begin
    pv[0] <= mem_rd && !rst;
    pa[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pa[i] <= pa[i-1];
    end
  end
  initial for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pa[i] = '0; end
  assign mem_rvalid = pv[LAT-1];
  always_comb for (int k = 0; k < 8; k++) mem_rdata[k*8 +: 8] = mb(pa[LAT-1] + AW'(k));

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 run hung act=%0d exp=%0d", cyc, 20000);
      finish_up();
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) rd_count++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 result with no accepted request", rsp_data, 0);
        else begin
          logic [31:0] e;
          string m;
          e = exp_q.pop_front();
          m = msg_q.pop_front();
          chk(rsp_data == e, m, rsp_data, e);
          chk(cyc - last_rv == 2, "R8 result delay after last beat", cyc - last_rv, 2);
          chk(!prev_rsp, "R8 single-cycle result pulse", prev_rsp, 0);
          chk(!busy, "R7 busy low with result", busy, 0);
        end
      end
      prev_rsp = rsp_valid;
      if (mem_rvalid) last_rv = cyc;
    end
  end

  task automatic issue(input logic [AW-1:0] a, input bit be, input bit spam, input string tag);
    bit two;
    logic [AW-1:0] base;
    two  = (a[2:0] > 3'd4);
    base = {a[AW-1:3], 3'b000};
    while (busy) @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = a;
    req_big_end = be;
    exp_q.push_back(expw(a, be));
    msg_q.push_back(tag);
    rd_expect += two ? 2 : 1;
    @(negedge clk);
    if (spam) begin
      req_addr    = a ^ 16'h0123;
      req_big_end = !be;
    end else req_valid = 1'b0;
    chk(mem_rd && mem_addr == base, "R1 first read next cycle at aligned base", {mem_rd, mem_addr}, {1'b1, base});
    chk(busy, "R7 busy after acceptance", busy, 1);
    @(negedge clk);
    chk(mem_rd == two, "R2 second read only for offsets 5..7", mem_rd, two);
    if (two) chk(mem_addr == base + AW'(8), "R2 second read address", mem_addr, base + AW'(8));
    @(negedge clk);
    chk(!mem_rd, "R2 R7 no further read", mem_rd, 0);
    if (spam) chk(busy, "R7 still busy while extra request held", busy, 1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd && !rsp_valid, "R9 outputs low in reset", {busy, mem_rd, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_rd && !rsp_valid, "R9 outputs low after reset", {busy, mem_rd, rsp_valid}, 0);

    for (int o = 0; o < 8; o++) begin
      issue(AW'(16'h0120 + o), 1'b0, 1'b0, "R3 R4 little-endian sweep");
      issue(AW'(16'h0240 + o), 1'b1, 1'b0, "R3 R5 big-endian sweep");
    end
    issue(16'h0306, 1'b0, 1'b0, "R6 order switch at run time, little");
    issue(16'h0306, 1'b1, 1'b0, "R6 order switch at run time, big");
    issue(16'h0403, 1'b0, 1'b1, "R6 R7 order flip and request while busy ignored");
    issue(16'h0507, 1'b1, 1'b1, "R6 R7 split load with request while busy");
    issue(16'h0004, 1'b0, 1'b0, "R2 R4 offset 4 fits one beat");
    issue(16'hFFFE, 1'b0, 1'b0, "R3 R4 wrap at top of address space");
    issue(16'hFFFD, 1'b1, 1'b0, "R3 R5 wrap at top of address space");

    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(rd_count == rd_expect, "R2 R7 total beat reads", rd_count, rd_expect);
    chk(exp_q.size() == 0, "R8 every request answered", exp_q.size(), 0);
    finish_up();
  end
endmodule